// File: doc/BRIEF.md
# Single-Cycle Banked Mersenne Twister Uniform Generator

This block produces one tempered 32-bit uniform pseudo-random word on every enabled clock, following the standard 32-bit Mersenne Twister recurrence with a state of N=624 words and a middle offset of M=397. It does not regenerate the whole state in one burst when the state runs out. Instead, every enabled cycle twists exactly one state word and emits that new word after tempering, so the latency is fixed and the initiation interval is one.

The state is spread over three simple dual-port RAM banks. The low bank holds indices [0, N-M), the middle bank holds [N-M, M) and the high bank holds [M, N). With this split, the two reads a cycle needs (the neighbour word i+1 and the far word i+M mod N) always fall in different banks. The one write goes through each bank's separate write port. The old value of word i is never read back from the RAM: it was fetched as the neighbour in the previous cycle and is kept in a register. Seeding fills the banks with the usual multiplicative recurrence over N cycles. This happens after reset with a default seed of 5489, or after a load pulse with a seed taken from the input. A tempered result of zero is emitted as one, so the word scaled by 2^-32 lies in (0,1].

Top module: `mt_banked_gen`

## Requirements
- R1: After reset release, or after the clock edge that samples seed_load_i high, the block spends exactly N=624 cycles seeding. valid_o stays 0 for those cycles whatever en_i does. With en_i held high, the first valid word appears after the 625th edge.
- R2: With the default seed 5489, the word stream equals the reference 32-bit Mersenne Twister output, starting 3499211612, 581869302, 3890346734.
- R3: Each edge that samples en_i high while the block is seeded raises valid_o with the next word of the sequence right after that edge (latency one). Consecutive enabled cycles give consecutive words with no gap, including where the state index wraps from N-1 to 0.
- R4: An edge that samples en_i low leaves valid_o at 0 and rnd_o unchanged, and does not advance the sequence. The next enabled word is the one that would have followed without the pause.
- R5: seed_load_i takes priority over en_i. The edge that samples it gives valid_o=0 and restarts seeding with seed_i. The stream that follows equals the reference generator seeded with that value.
- R6: rnd_o is never 0 while valid_o is 1; a tempered zero is emitted as 1.
- R7: Words after the first N stay exact. In later passes the twist reads state words that were already updated earlier in the same pass, as the sequential recurrence requires.
- R8: rst_ni is active-low and asynchronous. While it is low, valid_o and rnd_o are 0. After release the block reseeds with the default seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| seed_load_i | input | 1 | Restart seeding with seed_i |
| seed_i | input | 32 | Seed value sampled with seed_load_i |
| en_i | input | 1 | Request one word this cycle |
| rnd_o | output | 32 | Tempered uniform word |
| valid_o | output | 1 | rnd_o holds a new word this cycle |

## Verification
The bench targets the index wrap and the second pass through the state. An off-by-one in the far-word address or in the bank split, or a read that picks up a stale word, would first show up there as a wrong word near index 0 or after word 624. It counts the seeding window exactly, which would expose a handover that drops or repeats the first word. It pauses the enable in irregular patterns to expose a pipeline that skips a word or moves the neighbour register while idle. It also reloads a seed while enable is high, to catch a design that lets the request win over the reload.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef logic [31:0] word_t;
  typedef enum logic {PH_SEED, PH_RUN} phase_e;

  localparam word_t TWIST_XOR = 32'h9908_B0DF;
  localparam word_t SEED_MULT = 32'd1812433253;

  // next state word from old mt[i] (prev), mt[i+1] (nb), mt[i+M] (far)
  function automatic word_t twist(input word_t prev, input word_t nb, input word_t far);
    word_t y;
    y = {prev[31], nb[30:0]};
    return far ^ (y >> 1) ^ (y[0] ? TWIST_XOR : 32'h0);
  endfunction

  function automatic word_t seed_step(input word_t v, input word_t k);
    return SEED_MULT * (v ^ (v >> 30)) + k;
  endfunction
endpackage

// File: rtl/mt_bank.sv
module mt_bank #(
  parameter int DEPTH = 227,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/mt_temper.sv
module mt_temper
  import mt_pkg::*;
(
  input  word_t raw_i,
  output word_t out_o
);
  word_t t;

  always_comb begin
    t = raw_i;
    t = t ^ (t >> 11);
    t = t ^ ((t << 7) & 32'h9D2C_5680);
    t = t ^ ((t << 15) & 32'hEFC6_0000);
    t = t ^ (t >> 18);
    out_o = (t == 32'h0) ? 32'd1 : t;
  end
endmodule

// File: rtl/mt_banked_gen.sv
module mt_banked_gen
  import mt_pkg::*;
#(
  parameter int    N            = 624,
  parameter int    M            = 397,
  parameter word_t DEFAULT_SEED = 32'd5489
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        seed_load_i,
  input  logic [31:0] seed_i,
  input  logic        en_i,
  output logic [31:0] rnd_o,
  output logic        valid_o
);
  localparam int IW     = $clog2(N);
  localparam int LO_SZ  = N - M;
  localparam int MID_SZ = 2 * M - N;
  localparam int MAX_SZ = (LO_SZ > MID_SZ) ? LO_SZ : MID_SZ;
  localparam int AW     = $clog2(MAX_SZ);

  function automatic logic [1:0] bank_of(input logic [IW-1:0] j);
    if (j < IW'(N - M))  return 2'd0;
    else if (j < IW'(M)) return 2'd1;
    else                 return 2'd2;
  endfunction

  function automatic logic [AW-1:0] local_of(input logic [IW-1:0] j);
    if (j < IW'(N - M))  return AW'(j);
    else if (j < IW'(M)) return AW'(j - IW'(N - M));
    else                 return AW'(j - IW'(M));
  endfunction

  phase_e          phase_q;
  logic [IW-1:0]   seed_cnt_q, cur_q;
  word_t           seed_val_q, seed_q, prev_q;
  logic [1:0]      nb_sel_q, far_sel_q;

  logic            fire, rd_en, wr_act;
  logic [IW-1:0]   nxt_idx, rd_base, nb_idx, far_idx, wr_idx;
  word_t           wr_data, nb_word, far_word, twisted, tempered;
  word_t           bank_rd [3];

  assign fire   = (phase_q == PH_RUN) && en_i && !seed_load_i;
  assign rd_en  = fire || ((phase_q == PH_SEED) && (seed_cnt_q == IW'(N - 1)) && !seed_load_i);
  assign wr_act = (phase_q == PH_SEED) || fire;

  always_comb begin
    nxt_idx = (cur_q == IW'(N - 1)) ? '0 : cur_q + 1'b1;
    // reads are issued one cycle ahead of the index they serve
    rd_base = (phase_q == PH_SEED) ? '0 : nxt_idx;
    nb_idx  = (rd_base == IW'(N - 1)) ? '0 : rd_base + 1'b1;
    far_idx = (rd_base < IW'(N - M)) ? rd_base + IW'(M) : rd_base - IW'(N - M);
    wr_idx  = (phase_q == PH_SEED) ? seed_cnt_q : cur_q;
    case (nb_sel_q)
      2'd0:    nb_word = bank_rd[0];
      2'd1:    nb_word = bank_rd[1];
      default: nb_word = bank_rd[2];
    endcase
    case (far_sel_q)
      2'd0:    far_word = bank_rd[0];
      2'd1:    far_word = bank_rd[1];
      default: far_word = bank_rd[2];
    endcase
    twisted = twist(prev_q, nb_word, far_word);
    wr_data = (phase_q == PH_SEED) ? seed_val_q : twisted;
  end

  for (genvar b = 0; b < 3; b++) begin : g_bank
    localparam int DEPTH = (b == 1) ? MID_SZ : LO_SZ;
    mt_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk_i   (clk_i),
      .we_i    (wr_act && (bank_of(wr_idx) == 2'(b))),
      .waddr_i (local_of(wr_idx)),
      .wdata_i (wr_data),
      .re_i    (rd_en),
      .raddr_i ((bank_of(nb_idx) == 2'(b)) ? local_of(nb_idx) : local_of(far_idx)),
      .rdata_o (bank_rd[b])
    );
  end

  mt_temper u_temper (
    .raw_i (twisted),
    .out_o (tempered)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_SEED;
      seed_cnt_q <= '0;
      seed_val_q <= DEFAULT_SEED;
      seed_q     <= DEFAULT_SEED;
      cur_q      <= '0;
      prev_q     <= '0;
      nb_sel_q   <= '0;
      far_sel_q  <= '0;
      valid_o    <= 1'b0;
      rnd_o      <= '0;
    end else begin
      valid_o <= fire;
      if (fire) begin
        rnd_o  <= tempered;
        cur_q  <= nxt_idx;
        prev_q <= nb_word;  // neighbour becomes next cycle's old mt[i]
      end
      if (rd_en) begin
        nb_sel_q  <= bank_of(nb_idx);
        far_sel_q <= bank_of(far_idx);
      end
      if (seed_load_i) begin
        phase_q    <= PH_SEED;
        seed_cnt_q <= '0;
        seed_val_q <= seed_i;
        seed_q     <= seed_i;
      end else if (phase_q == PH_SEED) begin
        seed_val_q <= seed_step(seed_val_q, 32'(seed_cnt_q) + 32'd1);
        if (seed_cnt_q == IW'(N - 1)) begin
          phase_q <= PH_RUN;
          cur_q   <= '0;
          prev_q  <= seed_q;
        end else begin
          seed_cnt_q <= seed_cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mt_banked_gen_chk.sv
module mt_banked_gen_chk #(
  parameter int N = 624
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        seed_load_i,
  input logic        en_i,
  input logic [31:0] rnd_o,
  input logic        valid_o
);
  localparam int CW = $clog2(N + 2);
  logic [CW-1:0] quiet_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      quiet_cnt <= '0;
    else if (seed_load_i)             quiet_cnt <= '0;
    else if (quiet_cnt <= CW'(N))     quiet_cnt <= quiet_cnt + 1'b1;
  end

  assert_seed_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_cnt <= CW'(N)) |-> !valid_o);

  assert_valid_needs_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(en_i));

  assert_idle_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(rnd_o));

  assert_load_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> !valid_o);

  assert_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (rnd_o != 32'h0));
endmodule

bind mt_banked_gen mt_banked_gen_chk #(.N(N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .seed_load_i (seed_load_i),
  .en_i        (en_i),
  .rnd_o       (rnd_o),
  .valid_o     (valid_o)
);

// File: tb/mt_banked_gen_tb.sv
`timescale 1ns/1ps
module mt_banked_gen_tb;
  localparam int N = 624;

  logic        clk = 1'b0;
  logic        rst_ni, seed_load, en;
  logic [31:0] seed, rnd;
  logic        valid;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  int unsigned ref_mt [N];
  int          ref_idx;

  always #2 clk = ~clk;

  mt_banked_gen u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .seed_load_i (seed_load),
    .seed_i      (seed),
    .en_i        (en),
    .rnd_o       (rnd),
    .valid_o     (valid)
  );

  function automatic void ref_seed(input int unsigned s);
    ref_mt[0] = s;
    for (int i = 1; i < N; i++)
      ref_mt[i] = 32'd1812433253 * (ref_mt[i-1] ^ (ref_mt[i-1] >> 30)) + i;
    ref_idx = N;
  endfunction

  function automatic int unsigned ref_next();
    int unsigned y;
    if (ref_idx >= N) begin
      for (int k = 0; k < N; k++) begin
        y = (ref_mt[k] & 32'h8000_0000) | (ref_mt[(k + 1) % N] & 32'h7FFF_FFFF);
        ref_mt[k] = ref_mt[(k + 397) % N] ^ (y >> 1) ^ ((y & 1) != 0 ? 32'h9908_B0DF : 32'h0);
      end
      ref_idx = 0;
    end
    y = ref_mt[ref_idx];
    ref_idx++;
    y ^= y >> 11;
    y ^= (y << 7) & 32'h9D2C_5680;
    y ^= (y << 15) & 32'hEFC6_0000;
    y ^= y >> 18;
    return (y == 0) ? 32'd1 : y;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at the negedge right after reset release or the load edge
  task automatic wait_seeding(input string req);
    int early = 0;
    for (int j = 1; j <= N; j++) begin
      @(negedge clk);
      if (valid) early++;
    end
    check(early == 0, req, early, 0);
  endtask

  task automatic stream(input int count, input string req);
    int unsigned exp;
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      exp = ref_next();
      check(valid == 1'b1 && rnd == exp, req, rnd, exp);
      check(rnd != 0, "R6", rnd, 1);
    end
  endtask

  task automatic test_reset_state();
    rst_ni = 1'b0; seed_load = 1'b0; en = 1'b0; seed = '0;
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R8 valid in reset", valid, 0);
    check(rnd == 0, "R8 rnd in reset", rnd, 0);
  endtask

  task automatic test_default_seed();
    en = 1'b1;
    rst_ni = 1'b1;
    wait_seeding("R1 quiet while seeding");
    ref_seed(32'd5489);
    @(negedge clk);
    check(valid && rnd == 32'd3499211612, "R1 R2 first word", rnd, 32'd3499211612);
    void'(ref_next());
    stream(2, "R2 early words");
    stream(1300, "R3 R7 continuous across wrap");
  endtask

  task automatic test_stall();
    logic [31:0] last;
    int unsigned exp;
    for (int i = 0; i < 60; i++) begin
      last = rnd;
      en = ((i % 3) != 0) && !(i >= 30 && i < 42);
      @(negedge clk);
      if (en) begin
        exp = ref_next();
        check(valid && rnd == exp, "R4 resume after pause", rnd, exp);
      end else begin
        check(!valid, "R4 no valid when idle", valid, 0);
        check(rnd == last, "R4 output held", rnd, last);
      end
    end
    en = 1'b1;
    stream(20, "R4 stream after stalls");
  endtask

  task automatic test_reseed();
    seed_load = 1'b1; seed = 32'h1234_5678; en = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    check(!valid, "R5 load beats enable", valid, 0);
    wait_seeding("R5 reseed quiet");
    ref_seed(32'h1234_5678);
    stream(700, "R5 R7 new seed stream");
  endtask

  task automatic test_reset_midrun();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(!valid && rnd == 0, "R8 async reset", rnd, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    wait_seeding("R8 R1 quiet after reset");
    ref_seed(32'd5489);
    stream(20, "R8 default seed again");
  endtask

  initial begin
    test_reset_state();
    test_default_seed();
    test_stall();
    test_reseed();
    test_reset_midrun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule